// File: doc/BRIEF.md
# Phase-2 Bus Memory Responder

This block lets a synchronous FPGA design act as the memory of an external 8-bit microprocessor. The processor has a 16-bit address bus and puts a bank byte on the shared data lines while its phase-2 clock is low. A fast system clock oversamples that phase-2 clock through a synchroniser, and a four-state sequencer follows each bus cycle. On the detected rising edge it latches the bank byte, the address and the direction. It then reads a block-RAM style array and drives the byte while phase 2 is still high, so every access starts and completes inside the same bus cycle.

On a write cycle the block samples the data lines late in the high phase and commits the byte to the latched address once the falling edge is seen. A separate preload port fills the array before the processor runs. For example, storing 00 and 06 at the two reset-vector locations FFFC and FFFD makes the processor start at 0600. The data bus is split into an input, an output and an output enable. The latched bank byte is shown on an output and plays no part in decoding.

Top module: `cpubus_mem_responder`

## Requirements
- R1: While reset is high and on the first cycles after it, data_oe, data_out and bank_out are all 0.
- R2: bank_out takes the value on data_in at the detected rising edge of phi2 and holds it until the next detected rising edge.
- R3: On a read cycle (rw_in high), data_oe is high and data_out holds the addressed byte no later than 5 system clocks after phi2 rises. Both stay stable until phi2 falls.
- R4: On a write cycle (rw_in low), the byte on data_in during the last high clock of phi2 is stored at the latched address. A later read of that address returns it.
- R5: During a write cycle data_oe stays 0.
- R6: data_oe returns to 0 no more than 3 system clocks after phi2 falls, and one clock after the fall is detected.
- R7: Only the low MEM_AW bits of addr_in select a location. Addresses that differ only above bit MEM_AW-1 reach the same byte, and the bank byte has no effect on the selection.
- R8: With pre_we high, pre_data is written at pre_addr, and later bus reads return it. A bus write changes no location other than its target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2_in | input | 1 | Processor phase-2 clock, asynchronous to clk |
| addr_in | input | ADDR_W | Processor address bus |
| rw_in | input | 1 | High for read, low for write |
| data_in | input | DATA_W | Value seen on the shared data lines |
| data_out | output | DATA_W | Byte driven onto the data lines |
| data_oe | output | 1 | Output enable for data_out |
| bank_out | output | DATA_W | Latched bank byte |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | MEM_AW | Preload location |
| pre_data | input | DATA_W | Preload byte |

## Verification
The bench builds the block with MEM_AW = 10, which gives a 1 KiB array. The 10-bit index brings address aliasing within reach: 0440 folds onto 0040, and the vector locations FFFC/FFFD fold onto 3FC/3FD. The whole array can also be preloaded with a computed pattern in a short run. The phase-2 model uses 6 system clocks per half-period. That is close to the tightest high phase the synchroniser and the registered read allow, so the read-before-fall timing and the late write sample are tested with little margin.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_CAPTURE = 2'd1,
    SQ_FETCH   = 2'd2,
    SQ_DRIVE   = 2'd3
  } seq_t;
endpackage

// File: rtl/cbr_edge_detect.sv
module cbr_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic phi2_in,
  output logic early_high,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int CHAIN_W = SYNC_STAGES + 1;
  logic [CHAIN_W-1:0] chain;

  generate
    for (genvar g = 0; g < CHAIN_W; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= phi2_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign early_high = chain[0];
  assign level      = chain[SYNC_STAGES-1];
  assign rise       = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  assign fall       = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];
endmodule

// File: rtl/cbr_sequencer.sv
module cbr_sequencer
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              fall,
  input  logic              early_high,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rw_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] rdata,
  output logic              mem_re,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rw_lat,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic [DATA_W-1:0] bank_out
);
  seq_t              state;
  logic [MEM_AW-1:0] addr_q;
  logic              rw_q;
  logic [DATA_W-1:0] bank_q, dout_q, wr_q;
  logic              oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      addr_q <= '0;
      rw_q   <= 1'b1;
      bank_q <= '0;
      dout_q <= '0;
      wr_q   <= '0;
      oe_q   <= 1'b0;
    end else if (fall) begin
      state <= SQ_IDLE;
      oe_q  <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: if (rise) begin
          addr_q <= addr_in[MEM_AW-1:0];
          rw_q   <= rw_in;
          bank_q <= data_in;
          state  <= SQ_CAPTURE;
        end
        SQ_CAPTURE: state <= SQ_FETCH;
        SQ_FETCH: begin
          dout_q <= rdata;
          oe_q   <= rw_q;
          state  <= SQ_DRIVE;
        end
        SQ_DRIVE: if (early_high) wr_q <= data_in;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign mem_re    = (state == SQ_CAPTURE);
  assign mem_we    = (state == SQ_DRIVE) && fall && !rw_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wr_q;
  assign rw_lat    = rw_q;
  assign data_out  = dout_q;
  assign data_oe   = oe_q;
  assign bank_out  = bank_q;
endmodule

// File: rtl/cbr_mem.sv
module cbr_mem #(
  parameter int DATA_W = 8,
  parameter int MEM_AW = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [MEM_AW-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << MEM_AW;
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/cpubus_mem_responder.sv
module cpubus_mem_responder #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int MEM_AW      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rw_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic [DATA_W-1:0] bank_out,
  input  logic              pre_we,
  input  logic [MEM_AW-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data
);
  logic              phi_early, phi_level, phi_rise, phi_fall;
  logic              bus_re, bus_we, seq_rw;
  logic [MEM_AW-1:0] bus_addr, wr_addr;
  logic [DATA_W-1:0] bus_wdata, wr_data, rdata;

  cbr_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .phi2_in(phi2_in),
    .early_high(phi_early), .level(phi_level),
    .rise(phi_rise), .fall(phi_fall)
  );

  cbr_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_seq (
    .clk(clk), .rst(rst), .rise(phi_rise), .fall(phi_fall),
    .early_high(phi_early), .addr_in(addr_in), .rw_in(rw_in),
    .data_in(data_in), .rdata(rdata), .mem_re(bus_re), .mem_we(bus_we),
    .mem_addr(bus_addr), .mem_wdata(bus_wdata), .rw_lat(seq_rw),
    .data_out(data_out), .data_oe(data_oe), .bank_out(bank_out)
  );

  assign wr_addr = pre_we ? pre_addr : bus_addr;
  assign wr_data = pre_we ? pre_data : bus_wdata;

  cbr_mem #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .we(pre_we | bus_we), .waddr(wr_addr), .wdata(wr_data),
    .re(bus_re), .raddr(bus_addr), .rdata(rdata)
  );
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rise,
  input logic              fall,
  input logic              level,
  input logic              rw_lat,
  input logic              data_oe,
  input logic [DATA_W-1:0] data_out,
  input logic [DATA_W-1:0] bank_out
);
  p_bank_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(bank_out));

  p_drive_stable_r3: assert property (@(posedge clk) disable iff (rst)
    data_oe |=> (!data_oe || $stable(data_out)));

  p_drive_in_high_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe) |-> level);

  p_no_drive_on_write_r5: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> rw_lat);

  p_release_after_fall_r6: assert property (@(posedge clk) disable iff (rst)
    fall |=> !data_oe);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!data_oe && bank_out == '0));
endmodule

bind cpubus_mem_responder cbr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rise(phi_rise), .fall(phi_fall), .level(phi_level),
  .rw_lat(seq_rw), .data_oe(data_oe), .data_out(data_out), .bank_out(bank_out)
);

// File: tb/cpubus_mem_responder_test.sv
module cpubus_mem_responder_test;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int MAW = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phi2 = 1'b0;
  logic [AW-1:0] addr = '0;
  logic rw = 1'b1;
  logic [DW-1:0] cpu_d = '0;
  logic [DW-1:0] data_in, data_out, bank_out;
  logic data_oe;
  logic pre_we = 1'b0;
  logic [MAW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_data = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign data_in = data_oe ? data_out : cpu_d;

  cpubus_mem_responder #(.ADDR_W(AW), .DATA_W(DW), .MEM_AW(MAW)) uut (
    .clk(clk), .rst(rst), .phi2_in(phi2), .addr_in(addr), .rw_in(rw),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .bank_out(bank_out), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data)
  );

  // {addr16, bank8, read1, wdata8, expect8}
  localparam logic [40:0] VEC [9] = '{
    {16'h0010, 8'h00, 1'b1, 8'h00, 8'h73},
    {16'h0123, 8'h12, 1'b1, 8'h00, 8'hF8},
    {16'h0040, 8'h7E, 1'b0, 8'hAB, 8'h00},
    {16'h0040, 8'h01, 1'b1, 8'h00, 8'hAB},
    {16'h0440, 8'h33, 1'b1, 8'h00, 8'hAB},
    {16'h0041, 8'h02, 1'b1, 8'h00, 8'hCA},
    {16'h0200, 8'hFF, 1'b0, 8'h3C, 8'h00},
    {16'h0200, 8'h01, 1'b1, 8'h00, 8'h3C},
    {16'h03FF, 8'hC0, 1'b1, 8'h00, 8'hFC}
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic preload(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a[MAW-1:0]; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  // One bus cycle: low phase with bank byte, high phase with data.
  // Samples outputs just before phi2 falls.
  task automatic bus_cycle(input logic [AW-1:0] a, input logic [DW-1:0] bk,
                           input logic rd, input logic [DW-1:0] wd,
                           output logic [DW-1:0] got, output logic oe_seen,
                           output logic [DW-1:0] bank_seen);
    @(negedge clk);
    phi2 = 1'b0; addr = a; rw = rd; cpu_d = bk;
    repeat (HALF - 1) @(negedge clk);
    @(negedge clk);
    phi2 = 1'b1;
    repeat (3) @(negedge clk);
    cpu_d = rd ? 8'h00 : wd;
    repeat (HALF - 3) @(negedge clk);
    got = data_out; oe_seen = data_oe; bank_seen = bank_out;
    phi2 = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] got, bnk;
    logic oe;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 oe", {7'd0, data_oe}, 8'h00);
    chk("R1 data", data_out, 8'h00);
    chk("R1 bank", bank_out, 8'h00);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 oe after", {7'd0, data_oe}, 8'h00);

    // R8: fill array through the preload port
    for (int i = 0; i < (1 << MAW); i++) preload(i, 8'(i * 7 + 3));
    preload(16'hFFFC & ((1 << MAW) - 1), 8'h00);
    preload(16'hFFFD & ((1 << MAW) - 1), 8'h06);
    for (int i = 0; i < 4; i++) preload(16'h0300 + i, 8'hA9);

    // Table walk: R2, R3, R4, R5, R7, R8
    for (int v = 0; v < 9; v++) begin
      bus_cycle(VEC[v][40:25], VEC[v][24:17], VEC[v][16], VEC[v][15:8], got, oe, bnk);
      chk("R2 bank latch", bnk, VEC[v][24:17]);
      if (VEC[v][16]) begin
        chk("R3 oe on read", {7'd0, oe}, 8'h01);
        chk("R3/R4/R7/R8 read data", got, VEC[v][7:0]);
      end else begin
        chk("R5 no drive on write", {7'd0, oe}, 8'h00);
      end
    end

    // R6: output released shortly after phi2 falls
    bus_cycle(16'h0010, 8'h44, 1'b1, 8'h00, got, oe, bnk);
    chk("R6 oe before fall", {7'd0, oe}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R6 oe released", {7'd0, data_oe}, 8'h00);
    chk("R2 bank held in low phase", bank_out, 8'h44);

    // R8 reset vector fetch (aliased by R7)
    bus_cycle(16'hFFFC, 8'h00, 1'b1, 8'h00, got, oe, bnk);
    chk("R8 vector low", got, 8'h00);
    bus_cycle(16'hFFFD, 8'h00, 1'b1, 8'h00, got, oe, bnk);
    chk("R8 vector high", got, 8'h06);

    // Back-to-back reads of the A9 stream, A0 toggling each cycle
    for (int i = 0; i < 4; i++) begin
      bus_cycle(16'h0300 + 16'(i), 8'h00, 1'b1, 8'h00, got, oe, bnk);
      chk("R3 stream", got, 8'hA9);
    end

    // R7: bank byte does not change the selected location
    bus_cycle(16'h0301, 8'hEE, 1'b1, 8'h00, got, oe, bnk);
    chk("R7 bank ignored", got, 8'hA9);
    chk("R2 bank seen", bnk, 8'hEE);

    // R4 neighbours untouched after a write, plus final commit
    bus_cycle(16'h0100, 8'h00, 1'b0, 8'h5D, got, oe, bnk);
    bus_cycle(16'h0101, 8'h00, 1'b1, 8'h00, got, oe, bnk);
    chk("R8 neighbour kept", got, 8'(16'h101 * 7 + 3));
    bus_cycle(16'h0100, 8'h00, 1'b1, 8'h00, got, oe, bnk);
    chk("R4 write committed", got, 8'h5D);

    // R1: reset clears outputs mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 re-reset bank", bank_out, 8'h00);
    chk("R1 re-reset oe", {7'd0, data_oe}, 8'h00);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule